// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked request port and an external asynchronous static RAM of 256K bytes. The RAM is selected only when its active-low enable is low and its active-high enable is high at the same time. It has an active-low output enable and an active-low write enable, and one shared 8-bit data bus. A user sees only a simple handshake. While `ready` is high, one pulse of `req` starts one read or one write. The controller then drives the RAM strobes for as many clock cycles as the RAM's worst-case timing demands. `ready` returns only when the whole cycle time has passed.

Each analog minimum or maximum is converted into a cycle count with ceil(t / CLK_NS), and no count is less than one cycle. A parameter selects between a fast timing grade and a slow one. The fast grade uses a 70 ns cycle, a 50 ns write pulse, 60 ns address/enable to end of write, 30 ns data setup and 35 ns output-enable access. The slow grade uses 100, 60, 80, 40 and 50 ns. With the default 4 ns clock and the fast grade:
- A read holds the strobes for 18 cycles.
- A write holds WE low for 15 cycles and then recovers for 3 cycles.

Top module: `sram_strobe_top`

## Requirements
- R1: In reset and on the first cycle after a synchronous reset, the outputs are `memCe1N`=1, `memCe2`=0, `memOeN`=1, `memWeN`=1, `memDoutEn`=0 and `ready`=1. The reset may arrive in the middle of an operation.
- R2: Whenever `ready` is high, the RAM is deselected (`memCe1N`=1 and `memCe2`=0), and `memOeN` and `memWeN` are both high.
- R3: An accepted read (`reqWrite`=0) holds `memCe1N`=0, `memCe2`=1, `memWeN`=1 and `memOeN`=0 for exactly RD_CYC consecutive cycles. RD_CYC is the largest of the cycle time, address access and output-enable access counts (18 at defaults).
- R4: `rdData` takes the value on `memDin` at the end of the last cycle in which `memOeN` is low. It keeps that value until the next read completes, and a write does not change it.
- R5: An accepted write holds `memWeN` low for exactly WP_CYC consecutive cycles (15 at defaults) with the chip selected. WP_CYC is the largest of the write pulse, address-to-end, enable-to-end and data-setup counts. `memOeN` stays high for the whole write.
- R6: `memDoutEn` is high in every cycle in which `memWeN` is low and in the single cycle after `memWeN` rises, and in no other cycle. It is never high while `memOeN` is low.
- R7: `memAddr` is loaded only when a request is accepted and does not change while `ready` is low.
- R8: `ready` stays low for exactly 18 cycles after a read or a write is accepted (default parameters). A `req` raised while `ready` is low starts no operation.
- R9: Cycle counts are ceil(ns / CLK_NS) with a minimum of 1. A write's recovery lasts max(1, cycle-time count − WP_CYC) cycles.
- R10: While `memDoutEn` is high, `memDout` equals the write data that was accepted with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request, taken when `ready` is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address of the request |
| reqWdata | input | DATA_W | Data to write |
| ready | output | 1 | Idle and able to accept a request |
| rdData | output | DATA_W | Last captured read data |
| memAddr | output | ADDR_W | RAM address bus |
| memCe1N | output | 1 | RAM enable, active low |
| memCe2 | output | 1 | RAM enable, active high |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memDout | output | DATA_W | Data driven toward the RAM |
| memDoutEn | output | 1 | Drive enable for `memDout` |
| memDin | input | DATA_W | Data returned from the RAM bus |

## Verification
The hardest point to reach from the ports is the capture instant. The design could sample a cycle too early and still read the correct data from an ideal RAM. The bench therefore models a RAM that returns a poison value until its output enable has been low for the full access count, so any early capture shows up as a wrong byte. Two other cases are also awkward to reach: a request raised while the controller is busy, and a reset in the middle of a write. The bench drives both directly and then observes the strobes, the address and the ready signal.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_READ,
    PH_WRITE,
    PH_RECOVER
  } sramPhase_e;

  typedef struct packed {
    logic load;
    logic ceOn;
    logic oeOn;
    logic weOn;
    logic drvOn;
    logic capture;
  } sramStrobe_t;

  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int CLK_NS     = 4,
  parameter int SLOW_GRADE = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        reqWrite,
  output logic        ready,
  output sramStrobe_t strobe
);

  localparam int T_RC = SLOW_GRADE ? 100 : 70;
  localparam int T_AA = T_RC;
  localparam int T_OE = SLOW_GRADE ? 50 : 35;
  localparam int T_WP = SLOW_GRADE ? 60 : 50;
  localparam int T_AW = SLOW_GRADE ? 80 : 60;
  localparam int T_DW = SLOW_GRADE ? 40 : 30;
  localparam int T_WC = T_RC;

  localparam int RD_CYC  = maxOf(nsToCycles(T_RC, CLK_NS),
                                 maxOf(nsToCycles(T_AA, CLK_NS), nsToCycles(T_OE, CLK_NS)));
  localparam int WP_CYC  = maxOf(nsToCycles(T_WP, CLK_NS),
                                 maxOf(nsToCycles(T_AW, CLK_NS), nsToCycles(T_DW, CLK_NS)));
  localparam int REC_CYC = maxOf(1, nsToCycles(T_WC, CLK_NS) - WP_CYC);
  localparam int MAX_CYC = maxOf(RD_CYC, maxOf(WP_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);

  sramPhase_e       phase;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (req) phase <= reqWrite ? PH_WRITE : PH_READ;
        end
        PH_READ: begin
          if (cnt == RD_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_WRITE: begin
          if (cnt == WP_LAST) begin
            phase <= PH_RECOVER;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_RECOVER: begin
          if (cnt == REC_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    ready          = (phase == PH_IDLE);
    strobe.load    = ready && req;
    strobe.ceOn    = (phase != PH_IDLE);
    strobe.oeOn    = (phase == PH_READ);
    strobe.weOn    = (phase == PH_WRITE);
    strobe.drvOn   = (phase == PH_WRITE) || ((phase == PH_RECOVER) && (cnt == '0));
    strobe.capture = (phase == PH_READ) && (cnt == RD_LAST);
  end

  // R8: a busy controller cannot be idle in the next cycle unless its count has ended
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ && cnt != RD_LAST) |=> !ready);

endmodule

// File: rtl/sram_strobe_dp.sv
module sram_strobe_dp
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  sramStrobe_t       strobe,
  input  logic              ready,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
    end else begin
      if (strobe.load) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (strobe.capture) rdataReg <= memDin;
    end
  end

  always_comb begin
    memAddr   = addrReg;
    memDout   = wdataReg;
    memDoutEn = strobe.drvOn;
    memCe1N   = !strobe.ceOn;
    memCe2    = strobe.ceOn;
    memOeN    = !strobe.oeOn;
    memWeN    = !strobe.weOn;
    rdData    = rdataReg;
  end

  p_idle_deselect_r2: assert property (@(posedge clk) disable iff (rst)
    ready |-> (memCe1N && !memCe2 && memOeN && memWeN));

  p_read_not_write_r3: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> (memWeN && !memCe1N && memCe2));

  p_write_selected_r5: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> (!memCe1N && memCe2 && memOeN && memDoutEn));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (rst)
    memDoutEn |-> memOeN);

  p_drive_release_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |=> !memDoutEn);

  p_addr_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (!ready && !$past(ready)) |-> $stable(memAddr));

endmodule

// File: rtl/sram_strobe_top.sv
module sram_strobe_top
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 4,
  parameter int SLOW_GRADE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  sramStrobe_t strobe;

  sram_strobe_ctrl #(
    .CLK_NS    (CLK_NS),
    .SLOW_GRADE(SLOW_GRADE)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .reqWrite(reqWrite),
    .ready   (ready),
    .strobe  (strobe)
  );

  sram_strobe_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .ready    (ready),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDin   (memDin),
    .rdData   (rdData),
    .memAddr  (memAddr),
    .memCe1N  (memCe1N),
    .memCe2   (memCe2),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memDout  (memDout),
    .memDoutEn(memDoutEn)
  );

endmodule

// File: tb/test_sram_strobe_top.sv
module test_sram_strobe_top;

  localparam int CLK_NS  = 4;
  // R9: expected counts worked out here from the ns figures
  localparam int RD_EXP  = (70 + CLK_NS - 1) / CLK_NS;
  localparam int WP_EXP  = (60 + CLK_NS - 1) / CLK_NS;
  localparam int REC_EXP = RD_EXP - WP_EXP;
  localparam int CYC_EXP = RD_EXP;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        ready;
  logic [7:0]  rdData;
  logic [17:0] memAddr;
  logic        memCe1N, memCe2, memOeN, memWeN, memDoutEn;
  logic [7:0]  memDout;
  logic [7:0]  memDin;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_NS / 2) clk = ~clk;

  sram_strobe_top i_sram_strobe_top (
    .clk(clk), .rst(rst), .req(req), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .ready(ready), .rdData(rdData), .memAddr(memAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN),
    .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

  // RAM model: 64 slots tagged by full address, poison until access time has passed
  logic [7:0]  ramData [64];
  logic [17:0] ramTag  [64];
  logic        ramVal  [64];
  int          oeLowCnt = 0;
  wire         sel = !memCe1N && memCe2;

  initial for (int i = 0; i < 64; i++) begin
    ramVal[i] = 1'b0; ramData[i] = '0; ramTag[i] = '0;
  end

  always @(posedge clk) oeLowCnt <= (sel && !memOeN) ? oeLowCnt + 1 : 0;

  always @(posedge memWeN)
    if (memDoutEn === 1'b1 && sel) begin
      ramData[memAddr[5:0]] = memDout;
      ramTag[memAddr[5:0]]  = memAddr;
      ramVal[memAddr[5:0]]  = 1'b1;
    end

  always_comb begin
    if (sel && !memOeN && memWeN && oeLowCnt >= RD_EXP - 1)
      memDin = (ramVal[memAddr[5:0]] && ramTag[memAddr[5:0]] == memAddr)
               ? ramData[memAddr[5:0]] : 8'h00;
    else
      memDin = 8'hEE;
  end

  // Bus monitor
  int          weRun = 0, oeRun = 0, lastWe = 0, lastOe = 0, drvAfter = 0;
  int          violDrv = 0, violAddr = 0, violData = 0;
  logic        prevReady = 1'b1;
  logic [17:0] prevAddr = '0;
  logic [7:0]  curWdata = '0;

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (!rst) begin
      if (!memWeN) weRun = weRun + 1;
      else if (weRun != 0) begin lastWe = weRun; weRun = 0; end
      if (!memOeN) oeRun = oeRun + 1;
      else if (oeRun != 0) begin lastOe = oeRun; oeRun = 0; end
      if (memDoutEn && memWeN) drvAfter = drvAfter + 1; else drvAfter = 0;
      if (drvAfter > 1) violDrv++;
      if (!memWeN && !memDoutEn) violDrv++;
      if (memDoutEn && !memOeN) violDrv++;
      if (memDoutEn && memDout != curWdata) violData++;
      if (!ready && !prevReady && memAddr != prevAddr) violAddr++;
    end
    prevReady = ready;
    prevAddr  = memAddr;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    check({tag, " ce1n"}, int'(memCe1N), 1);
    check({tag, " ce2"}, int'(memCe2), 0);
    check({tag, " oen"}, int'(memOeN), 1);
    check({tag, " wen"}, int'(memWeN), 1);
    check({tag, " drv"}, int'(memDoutEn), 0);
    check({tag, " ready"}, int'(ready), 1);
  endtask

  task automatic doOp(input logic wr, input logic [17:0] a, input logic [7:0] d, output int busy);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    if (wr) curWdata = d;
    @(negedge clk);
    req = 1'b0;
    busy = 0;
    while (!ready) begin busy++; @(negedge clk); end
    #1;
  endtask

  typedef struct packed {
    logic        wr;
    logic [17:0] addr;
    logic [7:0]  data;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 18'h00005, 8'hA5},
    '{1'b1, 18'h3FFFF, 8'h5A},
    '{1'b1, 18'h20000, 8'h3C},
    '{1'b0, 18'h00005, 8'hA5},
    '{1'b0, 18'h3FFFF, 8'h5A},
    '{1'b0, 18'h20000, 8'h3C},
    '{1'b1, 18'h00005, 8'h00},
    '{1'b0, 18'h00005, 8'h00}
  };

  initial begin
    int busy;
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    checkIdle("R1 after reset");
    checkIdle("R2 idle");

    foreach (VECS[i]) begin
      doOp(VECS[i].wr, VECS[i].addr, VECS[i].data, busy);
      check("R8 busy cycles", busy, CYC_EXP);
      if (VECS[i].wr) begin
        check("R5 R9 we width", lastWe, WP_EXP);
        check("R9 recovery", busy - lastWe, REC_EXP);
      end else begin
        check("R3 R9 oe width", lastOe, RD_EXP);
        check("R4 read data", int'(rdData), int'(VECS[i].data));
      end
      check("R2 idle after op", int'(memCe1N && !memCe2), 1);
    end

    // R4: a write leaves rdData alone
    doOp(1'b1, 18'h00011, 8'h77, busy);
    check("R4 rdData held over write", int'(rdData), 8'h00);
    doOp(1'b0, 18'h00011, 8'h00, busy);
    check("R4 read back", int'(rdData), 8'h77);

    // R8: req while busy is ignored; R7 address unchanged
    @(negedge clk);
    req = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00022; reqWdata = 8'h99; curWdata = 8'h99;
    @(negedge clk);
    req = 1'b1; reqWrite = 1'b0; reqAddr = 18'h00033;
    repeat (5) @(negedge clk);
    req = 1'b0;
    while (!ready) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R8 no extra op ready", int'(ready), 1);
    check("R8 no extra op ce", int'(memCe1N), 1);
    check("R7 address kept", int'(memAddr), 18'h00022);
    doOp(1'b0, 18'h00022, 8'h00, busy);
    check("R8 busy write landed", int'(rdData), 8'h99);

    // R1: reset in the middle of a write
    @(negedge clk);
    req = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00030; reqWdata = 8'h11; curWdata = 8'h11;
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 mid write we low", int'(memWeN), 0);
    rst = 1'b1;
    @(negedge clk);
    checkIdle("R1 mid-op reset");
    rst = 1'b0;
    weRun = 0; drvAfter = 0;
    @(negedge clk);
    checkIdle("R1 after mid-op reset");

    check("R6 driver window", violDrv, 0);
    check("R7 address stability", violAddr, 0);
    check("R10 write data on bus", violData, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected<20000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule